// File: doc/BRIEF.md
# Interrupt Destination Match Unit

This block resolves the recipient set of an inter-processor interrupt request. The requester writes a high command word, which holds the 8-bit destination, and then a low command word, which holds the shorthand, the destination mode and the delivery mode. A write of the low word dispatches the request. For every one of N local units the block compares the request against that unit's configuration: its physical ID, its logical ID, its logical-format nibble and its enable. One cycle after the dispatch it presents the result as a registered target bitmask together with a one-cycle valid strobe.

In lowest-priority delivery the block selects exactly one recipient. It takes the first unit that both matched and is enabled, searching in rotating order from the unit after the one it picked last. The search runs in a single cycle. Delivering the vector into each unit is the job of logic outside this block.

Top module: `ipi_target_sel`

## Requirements
- R1: After reset, `tgt_valid` is 0, `tgt_mask` is all zero, and both command read-back words are zero. The rotating pointer starts at unit N-1, so the first lowest-priority search begins at unit 0.
- R2: A write of the high word keeps only bits 31:24 (the destination). `cmd_hi_rd` returns those bits with bits 23:0 reading as zero.
- R3: A write of the low word is stored and read back through `cmd_lo_rd` with bit 12 (delivery status) always clear.
- R4: Each low-word write produces exactly one `tgt_valid` pulse, in the cycle after the write. A high-word write on its own produces no pulse.
- R5: With shorthand (low bits 19:18) equal to 0 and destination mode (low bit 11) equal to 0, a unit matches when the destination is 0xFF or equals its ID. In every delivery mode other than lowest priority (low bits 10:8 not equal to 1), the mask is the match set, whatever the unit enables are.
- R6: With destination mode 1 and a unit format nibble of 0xF (flat), a unit matches when its logical ID ANDed with the destination is nonzero.
- R7: With destination mode 1 and a format nibble of 0x0 (cluster), a unit matches when the upper nibbles of logical ID and destination are equal and the lower nibbles share a set bit. Any other format nibble matches nothing.
- R8: Shorthand 1 selects only the source unit `src_unit`. Shorthand 2 selects all units. Shorthand 3 selects every unit except the source.
- R9: In lowest-priority mode (low bits 10:8 equal to 1), the mask is one-hot. It names the first unit that is matched and enabled, searching from the unit after the last one picked and wrapping around. The pointer then moves to the unit picked.
- R10: In lowest-priority mode with no unit both matched and enabled, the mask is zero, the valid strobe still fires, and the pointer is left unchanged.
- R11: When the high and low words are written in the same cycle, the dispatch uses the newly written destination.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_lo_we | input | 1 | Low command word write; dispatches the request |
| cmd_lo_wdata | input | 32 | Low command word data |
| cmd_hi_we | input | 1 | High command word write |
| cmd_hi_wdata | input | 32 | High command word data (destination in 31:24) |
| src_unit | input | 4 | Index of the requesting unit |
| unit_id | input | N*8 | Physical ID of each unit, 8 bits per unit |
| unit_lid | input | N*8 | Logical ID of each unit |
| unit_fmt | input | N*4 | Logical-format nibble of each unit (0xF flat, 0x0 cluster) |
| unit_en | input | N | Unit enabled |
| cmd_lo_rd | output | 32 | Low word read-back |
| cmd_hi_rd | output | 32 | High word read-back |
| tgt_mask | output | N | Target bitmask |
| tgt_valid | output | 1 | One-cycle strobe that qualifies `tgt_mask` |

## Verification
Two functions can fall in the same cycle: a high-word write that changes the destination, and the low-word write that dispatches a request. The bench writes both words in one cycle with a destination that differs from the stored one, and it requires the resulting mask to follow the new destination. A second collision happens in lowest-priority mode, where the pointer update and the next search meet. The bench sends lowest-priority requests back to back while it changes the enable set between them, and it compares each one-hot pick against its own rotating model. This includes a request that finds no eligible unit, which must leave the next pick unaffected.

// File: rtl/ipi_sel_pkg.sv
package ipi_sel_pkg;

  typedef enum logic [1:0] {
    SH_DEST   = 2'd0,
    SH_SELF   = 2'd1,
    SH_ALL    = 2'd2,
    SH_OTHERS = 2'd3
  } shorthand_e;

  localparam logic [2:0] DM_LOWPRI   = 3'd1;
  localparam logic [3:0] FMT_FLAT    = 4'hF;
  localparam logic [3:0] FMT_CLUSTER = 4'h0;
  localparam logic [7:0] DEST_BCAST  = 8'hFF;
  localparam int         STATUS_BIT  = 12;

  // logical-address comparison for one unit
  function automatic logic logical_hit(input logic [3:0] fmt,
                                       input logic [7:0] lid,
                                       input logic [7:0] dest);
    if (fmt == FMT_FLAT)
      return |(lid & dest);
    else if (fmt == FMT_CLUSTER)
      return (lid[7:4] == dest[7:4]) && |(lid[3:0] & dest[3:0]);
    else
      return 1'b0;
  endfunction

endpackage

// File: rtl/ipi_dest_match.sv
module ipi_dest_match
  import ipi_sel_pkg::*;
#(
  parameter int N  = 16,
  parameter int IW = 8,
  localparam int PW = (N > 1) ? $clog2(N) : 1
) (
  input  logic [IW-1:0]  dest,
  input  logic           logical_mode,
  input  shorthand_e     shorthand,
  input  logic [PW-1:0]  src,
  input  logic [N*IW-1:0] ids,
  input  logic [N*8-1:0] lids,
  input  logic [N*4-1:0] fmts,
  output logic [N-1:0]   hit
);

  for (genvar u = 0; u < N; u++) begin : g_unit
    logic addr_hit;
    always_comb begin
      if (logical_mode)
        addr_hit = logical_hit(fmts[u*4 +: 4], lids[u*8 +: 8], dest[7:0]);
      else
        addr_hit = (dest[7:0] == DEST_BCAST) || (dest == ids[u*IW +: IW]);
    end
    always_comb begin
      unique case (shorthand)
        SH_DEST:   hit[u] = addr_hit;
        SH_SELF:   hit[u] = (src == PW'(u));
        SH_ALL:    hit[u] = 1'b1;
        SH_OTHERS: hit[u] = (src != PW'(u));
        default:   hit[u] = 1'b0;
      endcase
    end
  end

endmodule

// File: rtl/ipi_rr_pick.sv
module ipi_rr_pick #(
  parameter int N = 16,
  localparam int PW = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]  req,
  input  logic [PW-1:0] last,
  output logic [N-1:0]  pick_oh,
  output logic [PW-1:0] pick_idx,
  output logic          any
);

  // rotated priority search starting one past the last winner
  always_comb begin
    int j;
    pick_oh  = '0;
    pick_idx = '0;
    any      = 1'b0;
    for (int k = 0; k < N; k++) begin
      j = int'(last) + 1 + k;
      if (j >= N) j = j - N;
      if (!any && req[j]) begin
        any        = 1'b1;
        pick_idx   = PW'(j);
        pick_oh[j] = 1'b1;
      end
    end
  end

endmodule

// File: rtl/ipi_target_sel.sv
module ipi_target_sel
  import ipi_sel_pkg::*;
#(
  parameter int N  = 16,
  parameter int IW = 8,
  localparam int PW = (N > 1) ? $clog2(N) : 1
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            cmd_lo_we,
  input  logic [31:0]     cmd_lo_wdata,
  input  logic            cmd_hi_we,
  input  logic [31:0]     cmd_hi_wdata,
  input  logic [PW-1:0]   src_unit,
  input  logic [N*IW-1:0] unit_id,
  input  logic [N*8-1:0]  unit_lid,
  input  logic [N*4-1:0]  unit_fmt,
  input  logic [N-1:0]    unit_en,
  output logic [31:0]     cmd_lo_rd,
  output logic [31:0]     cmd_hi_rd,
  output logic [N-1:0]    tgt_mask,
  output logic            tgt_valid
);

  logic [31:0]   lo_q, hi_q;
  logic [N-1:0]  mask_q;
  logic          valid_q, lp_q;
  logic [PW-1:0] ptr_q;

  logic [IW-1:0] dest;
  logic          is_lp;
  logic [N-1:0]  hit, pick_oh;
  logic [PW-1:0] pick_idx;
  logic          pick_any;

  assign dest  = cmd_hi_we ? cmd_hi_wdata[31:31-IW+1] : hi_q[31:31-IW+1];
  assign is_lp = (cmd_lo_wdata[10:8] == DM_LOWPRI);

  ipi_dest_match #(.N(N), .IW(IW)) i_match (
    .dest         (dest),
    .logical_mode (cmd_lo_wdata[11]),
    .shorthand    (shorthand_e'(cmd_lo_wdata[19:18])),
    .src          (src_unit),
    .ids          (unit_id),
    .lids         (unit_lid),
    .fmts         (unit_fmt),
    .hit          (hit)
  );

  ipi_rr_pick #(.N(N)) i_pick (
    .req      (hit & unit_en),
    .last     (ptr_q),
    .pick_oh  (pick_oh),
    .pick_idx (pick_idx),
    .any      (pick_any)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      lo_q    <= '0;
      hi_q    <= '0;
      mask_q  <= '0;
      valid_q <= 1'b0;
      lp_q    <= 1'b0;
      ptr_q   <= PW'(N - 1);
    end else begin
      valid_q <= cmd_lo_we;
      if (cmd_hi_we)
        hi_q <= {cmd_hi_wdata[31:31-IW+1], {(32-IW){1'b0}}};
      if (cmd_lo_we) begin
        lo_q <= cmd_lo_wdata & ~(32'h1 << STATUS_BIT);
        lp_q <= is_lp;
        if (is_lp) begin
          mask_q <= pick_oh;
          if (pick_any) ptr_q <= pick_idx;
        end else begin
          mask_q <= hit;
        end
      end
    end
  end

  assign cmd_lo_rd = lo_q;
  assign cmd_hi_rd = hi_q;
  assign tgt_mask  = mask_q;
  assign tgt_valid = valid_q;

  // R4
  valid_follows_write_chk: assert property (@(posedge clk) disable iff (rst)
    cmd_lo_we |=> tgt_valid);
  // R4
  no_spurious_valid_chk: assert property (@(posedge clk) disable iff (rst)
    !cmd_lo_we |=> !tgt_valid);
  // R9
  lowpri_onehot_chk: assert property (@(posedge clk) disable iff (rst)
    (tgt_valid && lp_q) |-> $onehot0(tgt_mask));
  // R9
  lowpri_enabled_chk: assert property (@(posedge clk) disable iff (rst)
    (tgt_valid && lp_q) |-> ((tgt_mask & ~$past(unit_en)) == '0));
  // R9
  lowpri_ptr_track_chk: assert property (@(posedge clk) disable iff (rst)
    (tgt_valid && lp_q && (tgt_mask != '0)) |-> tgt_mask[ptr_q]);
  // R10
  lowpri_ptr_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (tgt_valid && lp_q && (tgt_mask == '0)) |-> (ptr_q == $past(ptr_q)));

endmodule

// File: tb/test_ipi_target_sel.sv
`timescale 1ns/1ps
module test_ipi_target_sel;
  localparam int N = 16;

  logic clk = 0, rst = 1;
  logic cmd_lo_we = 0, cmd_hi_we = 0;
  logic [31:0] cmd_lo_wdata = 0, cmd_hi_wdata = 0;
  logic [3:0] src_unit = 0;
  logic [N*8-1:0] unit_id, unit_lid;
  logic [N*4-1:0] unit_fmt;
  logic [N-1:0] unit_en;
  logic [31:0] cmd_lo_rd, cmd_hi_rd;
  logic [N-1:0] tgt_mask;
  logic tgt_valid;

  logic [7:0] b_id [N];
  logic [7:0] b_lid[N];
  logic [3:0] b_fmt[N];
  logic [N-1:0] b_en;

  always_comb for (int i = 0; i < N; i++) begin
    unit_id[i*8 +: 8]  = b_id[i];
    unit_lid[i*8 +: 8] = b_lid[i];
    unit_fmt[i*4 +: 4] = b_fmt[i];
  end
  assign unit_en = b_en;

  ipi_target_sel #(.N(N)) i_ipi_target_sel (.*);

  always #2 clk = ~clk;

  int tests = 0, fails = 0;
  typedef struct { logic [N-1:0] mask; string tag; } exp_t;
  exp_t sb[$];
  logic [31:0] bhi = 0;
  int bptr = N - 1;

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [N-1:0] bmatch(logic [31:0] lo, logic [31:0] hi);
    logic [N-1:0] m;
    logic [7:0] d;
    d = hi[31:24];
    for (int i = 0; i < N; i++) begin
      case (lo[19:18])
        2'd1: m[i] = (i == int'(src_unit));
        2'd2: m[i] = 1'b1;
        2'd3: m[i] = (i != int'(src_unit));
        default:
          if (!lo[11]) m[i] = (d == 8'hFF) || (d == b_id[i]);
          else if (b_fmt[i] == 4'hF) m[i] = |(b_lid[i] & d);
          else if (b_fmt[i] == 4'h0)
            m[i] = (b_lid[i][7:4] == d[7:4]) && |(b_lid[i][3:0] & d[3:0]);
          else m[i] = 1'b0;
      endcase
    end
    return m;
  endfunction

  task automatic send(string tag, logic [31:0] lo, logic do_hi = 0, logic [31:0] hi = 0);
    logic [N-1:0] m, e;
    @(negedge clk);
    if (do_hi) begin
      cmd_hi_we = 1; cmd_hi_wdata = hi; bhi = {hi[31:24], 24'h0};
    end
    cmd_lo_we = 1; cmd_lo_wdata = lo;
    m = bmatch(lo, bhi);
    if (lo[10:8] == 3'd1) begin
      e = '0;
      for (int k = 0; k < N; k++) begin
        int j;
        j = (bptr + 1 + k) % N;
        if (e == '0 && m[j] && b_en[j]) begin e[j] = 1'b1; bptr = j; end
      end
    end else e = m;
    sb.push_back('{e, tag});
    @(negedge clk);
    cmd_lo_we = 0; cmd_hi_we = 0;
  endtask

  task automatic write_hi(logic [31:0] hi);
    @(negedge clk);
    cmd_hi_we = 1; cmd_hi_wdata = hi; bhi = {hi[31:24], 24'h0};
    @(negedge clk);
    cmd_hi_we = 0;
  endtask

  // monitor: compare each result against the scoreboard
  always @(negedge clk) if (!rst && tgt_valid) begin
    tests++;
    if (sb.size() == 0) begin
      fails++;
      $display("FAIL R4 unexpected valid actual=%h expected=none", tgt_mask);
    end else begin
      exp_t x;
      x = sb.pop_front();
      if (tgt_mask !== x.mask) begin
        fails++;
        $display("FAIL %s actual=%h expected=%h", x.tag, tgt_mask, x.mask);
      end
    end
  end

  initial begin
    #(200000 * 4);
    fails++;
    $display("FAIL watchdog actual=running expected=done");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    for (int i = 0; i < N; i++) begin
      b_id[i] = 8'h10 + 8'(i); b_lid[i] = 8'(1 << (i % 8)); b_fmt[i] = 4'hF;
    end
    b_en = '1;
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R1 reset state
    check("R1 valid", 32'(tgt_valid), 0);
    check("R1 mask", 32'(tgt_mask), 0);
    check("R1 lo_rd", cmd_lo_rd, 0);
    check("R1 hi_rd", cmd_hi_rd, 0);
    // R2 high word keeps destination only; R4 no pulse from it
    write_hi(32'hABCDEF12);
    check("R2 hi_rd", cmd_hi_rd, 32'hAB000000);
    @(negedge clk);
    // R3 status bit reads clear; flat dispatch also scored
    send("R3_R6 flat AB", 32'h0000_1F00 | 32'h800);
    check("R3 lo_rd", cmd_lo_rd, 32'h0000_0F00);
    // R5 physical
    write_hi(32'h1300_0000);
    send("R5 phys id", 32'h0);
    write_hi(32'hFF00_0000);
    send("R5 phys bcast", 32'h0);
    b_en = '0;
    send("R5 fixed ignores enable", 32'h0000_0000);
    b_en = '1;
    // R6 flat logical
    write_hi(32'h0500_0000);
    send("R6 flat", 32'h800);
    // R7 cluster
    for (int i = 0; i < N; i++) begin
      b_fmt[i] = 4'h0; b_lid[i] = {4'(i / 4), 4'(1 << (i % 4))};
    end
    write_hi(32'h2300_0000);
    send("R7 cluster", 32'h800);
    for (int i = 0; i < N; i++) b_fmt[i] = 4'h5;
    send("R7 bad format", 32'h800);
    for (int i = 0; i < N; i++) b_fmt[i] = 4'hF;
    // R8 shorthands
    src_unit = 4'd5;
    send("R8 self", 32'h0004_0000);
    send("R8 all", 32'h0008_0000);
    send("R8 others", 32'h000C_0000);
    // R9 lowest priority rotation
    write_hi(32'hFF00_0000);
    send("R9 lp first", 32'h100);
    send("R9 lp second", 32'h100);
    send("R9 lp third", 32'h100);
    b_en = '0; b_en[3] = 1; b_en[7] = 1;
    send("R9 lp enabled 3", 32'h100);
    send("R9 lp enabled 7", 32'h100);
    send("R9 lp wrap 3", 32'h100);
    // R10 no eligible unit, pointer kept
    write_hi(32'h1100_0000);
    send("R10 lp none", 32'h100);
    write_hi(32'hFF00_0000);
    send("R10 lp after none", 32'h100);
    b_en = '1;
    // R11 same-cycle high and low writes
    send("R11 same cycle", 32'h0, 1'b1, 32'h1900_0000);
    check("R11 hi_rd", cmd_hi_rd, 32'h1900_0000);
    send("R11 same cycle lp", 32'h100, 1'b1, 32'h0000_0000);
    repeat (4) @(negedge clk);
    check("R4 scoreboard drained", 32'(sb.size()), 0);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule